// File: doc/BRIEF.md
# Parallel PRBS5 rate-multiplying generator

This block emits the 31-bit maximal-length sequence of the polynomial x^5 + x^3 + 1 on a one-bit serial output, one new bit per enabled fast clock, while its five-stage state register advances only once every Q fast clocks. Each update jumps the register Q single steps at once through a fixed XOR network, so Q consecutive sequence bits are present on Q of its stages at the same time. A holding register captures those Q taps on the update edge, and a select counter steps through them, oldest phase first, so the fast stream matches a plain one-bit-per-clock generator bit for bit.

The parameter Q chooses a rate factor of 2 or 4. The Q-bit word being serialized is also driven out for debug. A synchronous reset loads the fixed seed, and an enable input freezes the select counter, the state register and both outputs while it is low.

Top module: `prbs5_rate_mult`

## Requirements
- R1: After a synchronous reset, serial_out is 1. word_out is 2'b01 for Q=2 and 4'b1001 for Q=4. Word bit i holds sequence bit a_i of a serial generator whose seed (stages D1..D5) is 0,1,0,0,1.
- R2: With Q=2, serial_out equals a reference serial generator bit for bit, with one new bit per enabled fast clock. The reference takes D1 <= D3 xor D5, shifts D1..D4 into D2..D5, outputs D5 and starts from the R1 seed.
- R3: With Q=4, serial_out equals the same reference serial generator bit for bit.
- R4: serial_out repeats with a period of exactly 31 enabled fast clocks.
- R5: Within a slow cycle, at select position i (0 to Q-1), serial_out equals word_out[i]. Position 0 comes first after a reset or a word update.
- R6: word_out changes only on the enabled fast clock edge that leaves select position Q-1.
- R7: While en is low, the select position, the state register, serial_out and word_out all hold their values.
- R8: The state register never reaches all zeros, so serial_out never shows five consecutive zeros.
- R9: After k slow cycles, word_out bit i equals sequence bit a_(Q*k+i). The register update equals Q single steps of the reference generator.
- R10: A synchronous reset asserted mid-run returns the block to the seed and to select position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast (bit-rate) clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable, one output bit per enabled edge |
| serial_out | output | 1 | Rate-multiplied sequence bit |
| word_out | output | Q | Held taps being serialized; bit 0 is emitted first |

## Verification
serial_out and word_out come straight from registers through the output mux, with no pipeline delay. After the edge that releases reset, the first sequence bit is already visible at the next falling edge. Each enabled rising edge brings the next bit into view half a period later, and word_out changes only after the edge that closes a slow cycle. The bench keeps a queue of expected bits that is popped only on enabled rising edges and compares at every falling edge, so disabled cycles and resets need no special timing. Its own position counter, kept in step with those edges, tells which word bits are due and when a word change is allowed.

// File: rtl/prbs5_pkg.sv
package prbs5_pkg;

   localparam int P5_STAGES = 5;
   localparam int P5_PERIOD = 31;

   // Stage vector indexed 1..5 in shift direction; stage 5 is the reference output.
   typedef logic [1:P5_STAGES] p5_state_t;

   // One step of the serial generator for x^5 + x^3 + 1.
   function automatic p5_state_t p5_step(input p5_state_t s);
      p5_state_t n;
      n[1] = s[3] ^ s[5];
      for (int k = 2; k <= P5_STAGES; k++) n[k] = s[k-1];
      return n;
   endfunction

   // n successive single steps; used only as an independent check of the jump network.
   function automatic p5_state_t p5_jump(input p5_state_t s, input int n);
      p5_state_t t;
      t = s;
      for (int k = 0; k < n; k++) t = p5_step(t);
      return t;
   endfunction

   // Stage that carries the i-th bit emitted in a slow cycle.
   function automatic int p5_tap_stage(input int i);
      return P5_STAGES - i;
   endfunction

endpackage

// File: rtl/prbs5_sel_counter.sv
module prbs5_sel_counter #(
   parameter int Q = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   output logic [1:0] sel,
   output logic       upd
);
   localparam logic [1:0] LAST = 2'(Q - 1);

   logic [1:0] sel_q;

   always_ff @(posedge clk) begin
      if (rst)
         sel_q <= 2'd0;
      else if (en)
         sel_q <= (sel_q == LAST) ? 2'd0 : sel_q + 2'd1;
   end

   assign sel = sel_q;
   assign upd = en & ~rst & (sel_q == LAST);

   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
      sel_q <= LAST);                                             // R5
   AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(sel_q));                                     // R7

endmodule

// File: rtl/prbs5_jump.sv
module prbs5_jump #(
   parameter int Q = 4
) (
   input  prbs5_pkg::p5_state_t cur,
   output prbs5_pkg::p5_state_t nxt
);
   generate
      if (Q == 2) begin : g_two
         // Two steps per update: two XOR gates.
         always_comb begin
            nxt[1] = cur[2] ^ cur[4];
            nxt[2] = cur[3] ^ cur[5];
            nxt[3] = cur[1];
            nxt[4] = cur[2];
            nxt[5] = cur[3];
         end
      end else if (Q == 4) begin : g_four
         // Four steps per update: four XOR sites.
         always_comb begin
            nxt[1] = cur[2] ^ cur[3] ^ cur[5];
            nxt[2] = cur[1] ^ cur[3];
            nxt[3] = cur[2] ^ cur[4];
            nxt[4] = cur[3] ^ cur[5];
            nxt[5] = cur[1];
         end
      end else begin : g_none
         assign nxt = cur;
      end
   endgenerate

endmodule

// File: rtl/prbs5_tap_hold.sv
module prbs5_tap_hold
   import prbs5_pkg::*;
#(
   parameter int        Q    = 4,
   parameter p5_state_t SEED = 5'b01001
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           upd,
   input  p5_state_t      nxt,
   output p5_state_t      state,
   output logic [Q-1:0]   word
);
   p5_state_t    state_q;
   logic [Q-1:0] word_q;
   logic [Q-1:0] seed_taps;
   logic [Q-1:0] nxt_taps;

   generate
      for (genvar i = 0; i < Q; i++) begin : g_tap
         assign seed_taps[i] = SEED[p5_tap_stage(i)];
         assign nxt_taps[i]  = nxt[p5_tap_stage(i)];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEED;
         word_q  <= seed_taps;
      end else if (upd) begin
         state_q <= nxt;
         word_q  <= nxt_taps;
      end
   end

   assign state = state_q;
   assign word  = word_q;

   AST_RESET_SEED: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_q == SEED));                           // R10
   AST_JUMP_MATCH: assert property (@(posedge clk) disable iff (rst)
      upd |=> (state_q == p5_jump($past(state_q), Q)));            // R9
   AST_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state_q != '0);                                              // R8
   AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(word_q));                                   // R6

endmodule

// File: rtl/prbs5_out_mux.sv
module prbs5_out_mux #(
   parameter int Q = 4
) (
   input  logic [1:0]   sel,
   input  logic [Q-1:0] word,
   output logic         ser
);
   generate
      if (Q == 2) begin : g_mux2
         assign ser = (sel == 2'd1) ? word[1] : word[0];
      end else if (Q == 4) begin : g_mux4
         // Select 00 -> bit 0, 01 -> bit 1, 10 -> bit 2, 11 -> bit 3.
         always_comb begin
            ser = (~sel[1] & ~sel[0] & word[0]) |
                  (~sel[1] &  sel[0] & word[1]) |
                  ( sel[1] & ~sel[0] & word[2]) |
                  ( sel[1] &  sel[0] & word[3]);
         end
      end else begin : g_mux_none
         assign ser = word[0];
      end
   endgenerate

endmodule

// File: rtl/prbs5_rate_mult.sv
module prbs5_rate_mult
   import prbs5_pkg::*;
#(
   parameter int        Q    = 4,
   parameter p5_state_t SEED = 5'b01001
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   output logic         serial_out,
   output logic [Q-1:0] word_out
);
   generate
      if (Q != 2 && Q != 4) begin : g_bad_q
         $error("prbs5_rate_mult: Q must be 2 or 4");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("prbs5_rate_mult: SEED must be non-zero");
      end
   endgenerate

   logic [1:0]   sel;
   logic         upd;
   p5_state_t    state;
   p5_state_t    nxt;
   logic [Q-1:0] word;

   prbs5_sel_counter #(.Q(Q)) u_sel (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .sel (sel),
      .upd (upd)
   );

   prbs5_jump #(.Q(Q)) u_jump (
      .cur (state),
      .nxt (nxt)
   );

   prbs5_tap_hold #(.Q(Q), .SEED(SEED)) u_hold (
      .clk   (clk),
      .rst   (rst),
      .upd   (upd),
      .nxt   (nxt),
      .state (state),
      .word  (word)
   );

   prbs5_out_mux #(.Q(Q)) u_mux (
      .sel  (sel),
      .word (word),
      .ser  (serial_out)
   );

   assign word_out = word;

   AST_FIRST_TAP: assert property (@(posedge clk) disable iff (rst)
      (sel == 2'd0) |-> (serial_out == state[P5_STAGES]));         // R5
   AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!en && !$past(rst)) |=> ($stable(serial_out) && $stable(word_out))); // R7

endmodule

// File: tb/prbs5_rate_mult_tb.sv
module prbs5_rate_mult_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       s2, s4;
   logic [1:0] w2;
   logic [3:0] w4;

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs5_rate_mult #(.Q(2)) u_dut (
      .clk(clk), .rst(rst), .en(en), .serial_out(s2), .word_out(w2));
   prbs5_rate_mult #(.Q(4)) u_dut4 (
      .clk(clk), .rst(rst), .en(en), .serial_out(s4), .word_out(w4));

   bit expq[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   int  pos2, pos4, idx, zrun;
   bit  chg2, chg4, frz;
   logic       ls2, ls4;
   logic [1:0] lw2;
   logic [3:0] lw4;
   bit  hist[0:30];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // Driver side of the scoreboard: independent serial reference from the seed.
   task automatic load_ref(input int n);
      logic [1:5] st;
      st = 5'b01001;
      expq.delete();
      for (int k = 0; k < n; k++) begin
         expq.push_back(st[5]);
         st = {st[3] ^ st[5], st[1], st[2], st[3], st[4]};
      end
   endtask

   // Monitor, rising edge: consume one expected bit per enabled edge.
   always @(posedge clk) begin
      if (rst) begin
         pos2 = 0; pos4 = 0; idx = 0; zrun = 0;
         chg2 = 1'b1; chg4 = 1'b1; frz = 1'b0;
      end else if (started && en) begin
         chg2 = (pos2 == 1);
         chg4 = (pos4 == 3);
         frz  = 1'b0;
         if (idx < 31) hist[idx] = ls4;
         else chk(ls4 == hist[idx % 31], "R4 period-31 repeat", ls4, hist[idx % 31]);
         zrun = ls2 ? 0 : zrun + 1;
         chk(zrun < 5, "R8 zero run", zrun, 4);
         idx++;
         pos2 = (pos2 + 1) % 2;
         pos4 = (pos4 + 1) % 4;
         void'(expq.pop_front());
      end else if (started) begin
         chg2 = 1'b0; chg4 = 1'b0; frz = 1'b1;
      end
   end

   // Monitor, falling edge: compare the outputs against the scoreboard.
   always @(negedge clk) begin
      if (started && !rst) begin
         chk(s2 == expq[0], "R2 serial Q=2", s2, expq[0]);
         chk(s4 == expq[0], "R3 serial Q=4", s4, expq[0]);
         chk(s2 == w2[pos2], "R5 order Q=2", s2, w2[pos2]);
         chk(s4 == w4[pos4], "R5 order Q=4", s4, w4[pos4]);
         for (int i = pos2; i < 2; i++)
            chk(w2[i] == expq[i-pos2], "R9 word Q=2", w2[i], expq[i-pos2]);
         for (int i = pos4; i < 4; i++)
            chk(w4[i] == expq[i-pos4], "R9 word Q=4", w4[i], expq[i-pos4]);
         if (!chg2) chk(w2 == lw2, "R6 word hold Q=2", w2, lw2);
         if (!chg4) chk(w4 == lw4, "R6 word hold Q=4", w4, lw4);
         if (frz) chk({s2, s4, w2, w4} == {ls2, ls4, lw2, lw4}, "R7 freeze",
                      {s2, s4, w2, w4}, {ls2, ls4, lw2, lw4});
      end
      ls2 = s2; ls4 = s4; lw2 = w2; lw4 = w4;
   end

   initial begin
      load_ref(400);
      repeat (3) @(posedge clk);
      #2 rst = 1'b0; en = 1'b1; started = 1'b1;
      @(negedge clk);
      chk(s2 == 1'b1, "R1 reset serial Q=2", s2, 1);
      chk(w2 == 2'b01, "R1 reset word Q=2", w2, 1);
      chk(s4 == 1'b1, "R1 reset serial Q=4", s4, 1);
      chk(w4 == 4'b1001, "R1 reset word Q=4", w4, 9);

      repeat (100) @(posedge clk);
      for (int c = 0; c < 60; c++) begin
         @(posedge clk);
         #2 en = (c % 3 != 0);
      end
      @(posedge clk);
      #2 en = 1'b0;
      repeat (8) @(posedge clk);
      #2 en = 1'b1;
      repeat (13) @(posedge clk);

      // Mid-run reset (R10)
      #2 rst = 1'b1;
      load_ref(400);
      repeat (2) @(posedge clk);
      #2 rst = 1'b0; en = 1'b1;
      @(negedge clk);
      chk(s2 == 1'b1, "R10 restart serial Q=2", s2, 1);
      chk(w2 == 2'b01, "R10 restart word Q=2", w2, 1);
      chk(s4 == 1'b1, "R10 restart serial Q=4", s4, 1);
      chk(w4 == 4'b1001, "R10 restart word Q=4", w4, 9);
      repeat (140) @(posedge clk);
      #2 en = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule